// File: doc/BRIEF.md
# Multi-Byte Access Byte Sequencer

This block takes one physical memory access from a processor: 1, 2, 3 or 4 bytes starting at any byte address, either a read or a write. The address is first gated by a 20th-bit enable: when that enable is low, bit 20 of the address is forced to zero. The block then picks one of two ways to carry out the access. An access that qualifies goes out as a single transaction on a word port. Every other access is broken into single-byte transactions, issued one after another on a byte port toward the downstream region router.

An access qualifies for the word port only when all of the following hold:
- it is 2 or 4 bytes long;
- its start address is naturally aligned to that length;
- it lies entirely below the configured memory size;
- it starts outside the legacy window (0x80000 to 0xFFFFF by default).

On the byte path, the address of each byte is the original address plus the byte's offset, gated again by the 20th-bit enable, so an access can wrap to address zero. Bytes that land at or above the memory size are never sent downstream: they read as 0xFF and their write data is dropped. Read bytes are packed little-endian into a result word. A one-cycle done pulse then marks the end of the access.

The block takes a new access only while idle. The result word holds its value until the next access is accepted.

Top module: `access_splitter`

## Requirements
- R1: After reset `req_ready` is 1, `word_valid`, `byte_valid` and `acc_done` are 0 and `acc_rdata` is 0.
- R2: A 4-byte access whose gated start address has bits [1:0] equal to 0, whose end (start + length) is at most MEM_SIZE and whose start is outside [WIN_LO, WIN_HI] is issued as exactly one word transaction with `word_len` = 4 at the gated start address, and no byte transaction.
- R3: A 2-byte access with bit 0 of the gated start clear, under the same range and window conditions, is issued as one word transaction with `word_len` = 2; a read returns the two bytes in `acc_rdata[15:0]` with `acc_rdata[31:16]` = 0.
- R4: Every other access is sequenced byte by byte. This covers a 1-byte or 3-byte length, a misaligned start, a start inside the window, and an end beyond MEM_SIZE.
- R5: Byte transactions are issued in ascending offset order k = 0..len-1. Write byte k carries `req_wdata[8k+7:8k]`. Read byte k lands in `acc_rdata[8k+7:8k]`, and lanes at or above len read 0.
- R6: The address of byte k is (original address + k) with bit 20 cleared when `a20_en` was low at acceptance, so an access can wrap from 0xFFFFF to 0x00000; the word path uses the gated start address.
- R7: A byte whose address is at or above MEM_SIZE is not issued downstream: it reads 0xFF, its write is dropped, and it takes one cycle; the in-range bytes of the same access complete normally.
- R8: A byte or word transaction keeps its valid and all its fields unchanged until its acknowledge is seen; the next byte is issued only after that acknowledge.
- R9: `req_ready` is 1 only while idle, and a request offered while busy is ignored. `acc_done` is a single-cycle pulse one cycle after the last transaction completes.
- R10: `acc_rdata` holds its value from the done pulse until the next access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | 32 | Byte start address, ungated |
| req_len | input | 3 | Access length in bytes, 1 to 4 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, byte k in bits [8k+7:8k] |
| a20_en | input | 1 | 0 forces address bit 20 to zero |
| word_valid | output | 1 | Word transaction pending |
| word_ack | input | 1 | Word transaction accepted |
| word_addr | output | 32 | Aligned, gated start address |
| word_len | output | 3 | Word transaction length, 2 or 4 |
| word_write | output | 1 | Word transaction is a write |
| word_wdata | output | 32 | Word write data |
| word_rdata | input | 32 | Word read data, valid with `word_ack` |
| byte_valid | output | 1 | Byte transaction pending |
| byte_ack | input | 1 | Byte transaction accepted |
| byte_addr | output | 32 | Gated byte address |
| byte_write | output | 1 | Byte transaction is a write |
| byte_wdata | output | 8 | Byte write data |
| byte_rdata | input | 8 | Byte read data, valid with `byte_ack` |
| acc_done | output | 1 | One-cycle end-of-access pulse |
| acc_rdata | output | 32 | Little-endian read result |

## Verification
The bench targets the places where the choice between the word path and the byte path is easy to get wrong.
- An aligned access that starts inside the legacy window, or that runs past the memory size, has to be split into bytes. A design that keys only on alignment would send it as one word.
- An access that crosses 0xFFFFF with the 20th-bit enable low must wrap to 0x00000. A design that gates only the start address would land the later bytes above 1 MB instead.
- Accesses that straddle or lie wholly past the memory end must return 0xFF bytes without any downstream traffic. A design that gets this wrong either issues illegal addresses or returns stale lanes.
- Downstream acknowledges arrive after varying delays, and junk requests are offered while the block is busy. A design that advances without an acknowledge, or accepts a request mid-access, emits transactions the bench does not expect.

// File: rtl/access_splitter_pkg.sv
package access_splitter_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int IDX_W   = $clog2(LANES);
    localparam int LEN_W   = IDX_W + 1;
    localparam int GATE_BIT = 20;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FAST = 2'd1,
        ST_BYTE = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic              gate_on;
    } acc_req_t;

    // Clear the gated address bit when the gate enable is low.
    function automatic logic [ADDR_W-1:0] gate_addr(input logic [ADDR_W-1:0] a,
                                                    input logic on);
        logic [ADDR_W-1:0] m;
        m = a;
        if (!on) m[GATE_BIT] = 1'b0;
        return m;
    endfunction

    // One bit per lane, set for lanes below the access length.
    function automatic logic [LANES-1:0] lanes_used(input logic [LEN_W-1:0] n);
        logic [LANES-1:0] m;
        for (int k = 0; k < LANES; k++) m[k] = (k < int'(n));
        return m;
    endfunction

endpackage

// File: rtl/access_splitter_classify.sv
module access_splitter_classify
    import access_splitter_pkg::*;
#(
    parameter logic [ADDR_W:0]   MEM_SIZE = 33'h0_0020_0000,
    parameter logic [ADDR_W-1:0] WIN_LO   = 32'h0008_0000,
    parameter logic [ADDR_W-1:0] WIN_HI   = 32'h000F_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              gate_on,
    output logic [ADDR_W-1:0] base,
    output logic              fast
);
    logic [ADDR_W:0]  end_sum;
    logic [LEN_W-1:0] len_m1;
    logic             fits;
    logic             in_win;
    logic             pow2;
    logic             aligned;

    always_comb begin
        base    = gate_addr(addr, gate_on);
        end_sum = {1'b0, base} + (ADDR_W+1)'(len);
        fits    = (end_sum <= MEM_SIZE);
        in_win  = (base >= WIN_LO) && (base <= WIN_HI);
        len_m1  = len - LEN_W'(1);
        pow2    = ((len & len_m1) == '0) && (len > LEN_W'(1));
        aligned = (({1'b0, base[IDX_W-1:0]} & len_m1) == '0);
        fast    = fits && !in_win && pow2 && aligned;
    end

endmodule

// File: rtl/access_splitter_step.sv
module access_splitter_step
    import access_splitter_pkg::*;
#(
    parameter logic [ADDR_W:0] MEM_SIZE = 33'h0_0020_0000
) (
    input  logic [ADDR_W-1:0] orig_addr,
    input  logic [IDX_W-1:0]  idx,
    input  logic              gate_on,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              live
);
    logic [ADDR_W-1:0] raw;

    always_comb begin
        raw       = orig_addr + ADDR_W'(idx);
        byte_addr = gate_addr(raw, gate_on);
        live      = ({1'b0, byte_addr} < MEM_SIZE);
    end

endmodule

// File: rtl/access_splitter_gather.sv
module access_splitter_gather
    import access_splitter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              word_ld,
    input  logic [DATA_W-1:0] word_data,
    input  logic [LEN_W-1:0]  len,
    input  logic              byte_ld,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        byte_data,
    output logic [DATA_W-1:0] rdata
);
    logic [LANES-1:0] used;

    always_comb used = lanes_used(len);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_q;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                lane_q <= '0;
            end else if (word_ld && used[g]) begin
                lane_q <= word_data[8*g +: 8];
            end else if (byte_ld && (idx == IDX_W'(g))) begin
                lane_q <= byte_data;
            end
        end

        assign rdata[8*g +: 8] = lane_q;
    end

endmodule

// File: rtl/access_splitter.sv
module access_splitter
    import access_splitter_pkg::*;
#(
    parameter logic [ADDR_W:0]   MEM_SIZE = 33'h0_0020_0000,
    parameter logic [ADDR_W-1:0] WIN_LO   = 32'h0008_0000,
    parameter logic [ADDR_W-1:0] WIN_HI   = 32'h000F_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              a20_en,
    output logic              word_valid,
    input  logic              word_ack,
    output logic [ADDR_W-1:0] word_addr,
    output logic [LEN_W-1:0]  word_len,
    output logic              word_write,
    output logic [DATA_W-1:0] word_wdata,
    input  logic [DATA_W-1:0] word_rdata,
    output logic              byte_valid,
    input  logic              byte_ack,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              byte_write,
    output logic [7:0]        byte_wdata,
    input  logic [7:0]        byte_rdata,
    output logic              acc_done,
    output logic [DATA_W-1:0] acc_rdata
);
    seq_state_e        state_q;
    acc_req_t          cur_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;

    logic [ADDR_W-1:0] in_base;
    logic              in_fast;
    logic [ADDR_W-1:0] step_addr;
    logic              step_live;
    logic              accept;
    logic              byte_step;
    logic              last_byte;
    logic [LEN_W-1:0]  len_m1;
    acc_req_t          in_req;

    // Decide the path for the incoming request.
    access_splitter_classify #(
        .MEM_SIZE (MEM_SIZE),
        .WIN_LO   (WIN_LO),
        .WIN_HI   (WIN_HI)
    ) u_classify (
        .addr    (req_addr),
        .len     (req_len),
        .gate_on (a20_en),
        .base    (in_base),
        .fast    (in_fast)
    );

    // Address and range of the current byte of the latched request.
    access_splitter_step #(
        .MEM_SIZE (MEM_SIZE)
    ) u_step (
        .orig_addr (cur_q.addr),
        .idx       (idx_q),
        .gate_on   (cur_q.gate_on),
        .byte_addr (step_addr),
        .live      (step_live)
    );

    always_comb begin
        in_req.addr    = req_addr;
        in_req.len     = req_len;
        in_req.write   = req_write;
        in_req.wdata   = req_wdata;
        in_req.gate_on = a20_en;
        accept    = req_valid && (state_q == ST_IDLE);
        len_m1    = cur_q.len - LEN_W'(1);
        last_byte = ({1'b0, idx_q} == len_m1);
        // A byte outside memory needs no acknowledge.
        byte_step = (state_q == ST_BYTE) && (!step_live || byte_ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            base_q  <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_q   <= in_req;
                        base_q  <= in_base;
                        idx_q   <= '0;
                        state_q <= in_fast ? ST_FAST : ST_BYTE;
                    end
                end
                ST_FAST: begin
                    if (word_ack) state_q <= ST_DONE;
                end
                ST_BYTE: begin
                    if (byte_step) begin
                        if (last_byte) state_q <= ST_DONE;
                        else           idx_q   <= idx_q + IDX_W'(1);
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    access_splitter_gather u_gather (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .word_ld   ((state_q == ST_FAST) && word_ack && !cur_q.write),
        .word_data (word_rdata),
        .len       (cur_q.len),
        .byte_ld   (byte_step && !cur_q.write),
        .idx       (idx_q),
        .byte_data (step_live ? byte_rdata : 8'hFF),
        .rdata     (acc_rdata)
    );

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        word_valid = (state_q == ST_FAST);
        word_addr  = base_q;
        word_len   = cur_q.len;
        word_write = cur_q.write;
        word_wdata = cur_q.wdata;
        byte_valid = (state_q == ST_BYTE) && step_live;
        byte_addr  = step_addr;
        byte_write = cur_q.write;
        byte_wdata = cur_q.wdata[8*idx_q +: 8];
        acc_done   = (state_q == ST_DONE);
    end

endmodule

// File: rtl/access_splitter_chk.sv
module access_splitter_chk
    import access_splitter_pkg::*;
#(
    parameter logic [ADDR_W:0] MEM_SIZE = 33'h0_0020_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              word_valid,
    input logic              word_ack,
    input logic [ADDR_W-1:0] word_addr,
    input logic [LEN_W-1:0]  word_len,
    input logic              word_write,
    input logic [DATA_W-1:0] word_wdata,
    input logic              byte_valid,
    input logic              byte_ack,
    input logic [ADDR_W-1:0] byte_addr,
    input logic              byte_write,
    input logic [7:0]        byte_wdata,
    input logic              acc_done,
    input logic [DATA_W-1:0] acc_rdata
);
    // R8
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid && !byte_ack |=> byte_valid && $stable(byte_addr)
                                    && $stable(byte_write) && $stable(byte_wdata));

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid && !word_ack |=> word_valid && $stable(word_addr) && $stable(word_len)
                                    && $stable(word_write) && $stable(word_wdata));

    // R7
    byte_range_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> ({1'b0, byte_addr} < MEM_SIZE));

    // R2
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid && (word_len == LEN_W'(4)) |-> (word_addr[1:0] == 2'b00));

    // R3
    half_align_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid && (word_len == LEN_W'(2)) |-> (word_addr[0] == 1'b0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        acc_done |=> !acc_done);

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid || byte_valid || acc_done) |-> !req_ready);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_done || (req_ready && !req_valid)) |=> $stable(acc_rdata));

endmodule

bind access_splitter access_splitter_chk #(.MEM_SIZE(MEM_SIZE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .word_valid (word_valid),
    .word_ack   (word_ack),
    .word_addr  (word_addr),
    .word_len   (word_len),
    .word_write (word_write),
    .word_wdata (word_wdata),
    .byte_valid (byte_valid),
    .byte_ack   (byte_ack),
    .byte_addr  (byte_addr),
    .byte_write (byte_write),
    .byte_wdata (byte_wdata),
    .acc_done   (acc_done),
    .acc_rdata  (acc_rdata)
);

// File: tb/access_splitter_bench.sv
module access_splitter_bench;

    localparam logic [32:0] MEMSZ = 33'h0_0020_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_len = 3'd1;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        a20_en = 1'b1;
    logic        word_valid;
    logic        word_ack = 1'b0;
    logic [31:0] word_addr;
    logic [2:0]  word_len;
    logic        word_write;
    logic [31:0] word_wdata;
    logic [31:0] word_rdata = '0;
    logic        byte_valid;
    logic        byte_ack = 1'b0;
    logic [31:0] byte_addr;
    logic        byte_write;
    logic [7:0]  byte_wdata;
    logic [7:0]  byte_rdata = '0;
    logic        acc_done;
    logic [31:0] acc_rdata;

    always #10 clk = ~clk;

    access_splitter u_access_splitter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_wdata(req_wdata), .a20_en(a20_en),
        .word_valid(word_valid), .word_ack(word_ack), .word_addr(word_addr),
        .word_len(word_len), .word_write(word_write), .word_wdata(word_wdata),
        .word_rdata(word_rdata),
        .byte_valid(byte_valid), .byte_ack(byte_ack), .byte_addr(byte_addr),
        .byte_write(byte_write), .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
        .acc_done(acc_done), .acc_rdata(acc_rdata)
    );

    typedef struct packed {
        logic        word;
        logic [31:0] addr;
        logic [2:0]  len;
        logic        wr;
        logic [31:0] data;
    } xact_t;

    xact_t       expq[$];
    logic [7:0]  mem [int unsigned];
    int          n_chk = 0;
    int          n_fail = 0;
    int          dly = 0;
    int          seed = 0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A ^ {3'b000, a[20:16]};
    endfunction

    function automatic logic [31:0] gate(input logic [31:0] a, input logic en);
        return en ? a : (a & ~32'h0010_0000);
    endfunction

    // Downstream responder and per-cycle comparison against the expected queue.
    always @(negedge clk) begin
        byte_ack = 1'b0;
        word_ack = 1'b0;
        if (!rst && (byte_valid || word_valid)) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected transaction", {32'b0, byte_valid ? byte_addr : word_addr}, 0);
            end else if (dly > 0) begin
                dly--;
            end else begin
                xact_t h;
                h = expq.pop_front();
                if (byte_valid) begin
                    check(!h.word, "R4 byte vs word path", 1, {63'b0, h.word});
                    check(byte_addr == h.addr, "R6 byte address", byte_addr, h.addr);
                    check(byte_write == h.wr, "R5 byte write flag", byte_write, h.wr);
                    if (h.wr) begin
                        check(byte_wdata == h.data[7:0], "R5 byte write data", byte_wdata, h.data[7:0]);
                        mem[byte_addr] = byte_wdata;
                    end
                    byte_rdata = mem_rd(byte_addr);
                    byte_ack = 1'b1;
                end else begin
                    check(h.word, "R2 word vs byte path", 1, {63'b0, h.word});
                    check(word_addr == h.addr, "R2 word address", word_addr, h.addr);
                    check(word_len == h.len, "R3 word length", word_len, h.len);
                    check(word_write == h.wr, "R2 word write flag", word_write, h.wr);
                    for (int k = 0; k < 4; k++) begin
                        if (k < int'(word_len)) begin
                            if (word_write) mem[word_addr + k] = word_wdata[8*k +: 8];
                            word_rdata[8*k +: 8] = mem_rd(word_addr + k);
                        end else begin
                            word_rdata[8*k +: 8] = 8'hC3;
                        end
                    end
                    word_ack = 1'b1;
                end
                seed++;
                dly = seed % 3;
            end
        end
    end

    task automatic do_access(input logic [31:0] addr, input logic [2:0] len,
                             input logic wr, input logic [31:0] wd,
                             input logic a20, input bit garble, input string tag);
        logic [31:0] base, ba, exp_rd;
        logic [32:0] endsum;
        bit          fast;
        int          t;
        xact_t       x;
        base   = gate(addr, a20);
        endsum = {1'b0, base} + {30'b0, len};
        fast   = (endsum <= MEMSZ) && !(base >= 32'h8_0000 && base <= 32'hF_FFFF)
                 && ((len == 3'd4 && base[1:0] == 2'b00) || (len == 3'd2 && base[0] == 1'b0));
        exp_rd = '0;
        if (fast) begin
            x = '{word: 1'b1, addr: base, len: len, wr: wr, data: wd};
            expq.push_back(x);
            for (int k = 0; k < int'(len); k++) exp_rd[8*k +: 8] = mem_rd(base + k);
        end else begin
            for (int k = 0; k < int'(len); k++) begin
                ba = gate(addr + k, a20);
                if ({1'b0, ba} < MEMSZ) begin
                    x = '{word: 1'b0, addr: ba, len: 3'd1, wr: wr, data: {24'b0, wd[8*k +: 8]}};
                    expq.push_back(x);
                    exp_rd[8*k +: 8] = mem_rd(ba);
                end else begin
                    exp_rd[8*k +: 8] = 8'hFF;
                end
            end
        end
        if (wr) exp_rd = '0;

        @(negedge clk);
        check(req_ready, {"R9 ready when idle ", tag}, req_ready, 1);
        req_valid = 1'b1; req_addr = addr; req_len = len;
        req_write = wr;   req_wdata = wd;  a20_en = a20;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!acc_done && t < 200) begin
            check(!req_ready, {"R9 busy not ready ", tag}, req_ready, 0);
            if (garble) begin
                req_valid = 1'b1; req_addr = 32'h0000_0040; req_len = 3'd1;
            end
            @(negedge clk);
            t++;
        end
        req_valid = 1'b0;
        check(acc_done, {"R9 done reached ", tag}, acc_done, 1);
        check(expq.size() == 0, {"R4 all transactions issued ", tag}, expq.size(), 0);
        check(acc_rdata == exp_rd, {"R5 read result ", tag}, acc_rdata, exp_rd);
        @(negedge clk);
        check(!acc_done, {"R9 done one cycle ", tag}, acc_done, 0);
        check(acc_rdata == exp_rd, {"R10 result held ", tag}, acc_rdata, exp_rd);
        @(negedge clk);
        check(acc_rdata == exp_rd, {"R10 result held idle ", tag}, acc_rdata, exp_rd);
        expq.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(!word_valid && !byte_valid, "R1 no valid after reset", {word_valid, byte_valid}, 0);
        check(!acc_done, "R1 done low after reset", acc_done, 0);
        check(acc_rdata == 32'h0, "R1 rdata zero after reset", acc_rdata, 0);

        // R2 aligned word write then read
        do_access(32'h0000_1000, 3'd4, 1'b1, 32'hDEAD_BEEF, 1'b1, 0, "R2 word write");
        do_access(32'h0000_1000, 3'd4, 1'b0, 32'h0, 1'b1, 0, "R2 word read");
        // R3 aligned halfword read, upper lanes zero
        do_access(32'h0000_2002, 3'd2, 1'b0, 32'h0, 1'b1, 0, "R3 half read");
        do_access(32'h0000_2004, 3'd2, 1'b1, 32'h1234_ABCD, 1'b1, 0, "R3 half write");
        do_access(32'h0000_2004, 3'd4, 1'b0, 32'h0, 1'b1, 0, "R3 half readback");
        // R4 misaligned, length 3, length 1, window
        do_access(32'h0000_1001, 3'd4, 1'b1, 32'hA1B2_C3D4, 1'b1, 1, "R4 misaligned write");
        do_access(32'h0000_1001, 3'd4, 1'b0, 32'h0, 1'b1, 0, "R4 misaligned read");
        do_access(32'h0000_3000, 3'd3, 1'b0, 32'h0, 1'b1, 0, "R4 three byte read");
        do_access(32'h0000_0010, 3'd1, 1'b1, 32'h0000_0077, 1'b1, 0, "R4 single byte write");
        do_access(32'h0008_0000, 3'd4, 1'b0, 32'h0, 1'b1, 0, "R4 window aligned read");
        do_access(32'h000F_FFFC, 3'd2, 1'b1, 32'h0000_5566, 1'b1, 1, "R4 window half write");
        // R6 gate off: wrap from 0xFFFFF to 0
        do_access(32'h000F_FFFE, 3'd4, 1'b1, 32'h0403_0201, 1'b0, 0, "R6 wrap write");
        do_access(32'h0000_0000, 3'd2, 1'b0, 32'h0, 1'b1, 0, "R6 wrap readback low");
        do_access(32'h000F_FFFE, 3'd4, 1'b0, 32'h0, 1'b1, 0, "R6 no wrap gate on");
        do_access(32'h0010_0004, 3'd4, 1'b0, 32'h0, 1'b0, 0, "R6 gated word path");
        // R7 end beyond memory
        do_access(32'h001F_FFFE, 3'd4, 1'b0, 32'h0, 1'b1, 0, "R7 straddle read");
        do_access(32'h001F_FFFE, 3'd4, 1'b1, 32'hEEDD_CCBB, 1'b1, 0, "R7 straddle write");
        do_access(32'h001F_FFFC, 3'd4, 1'b0, 32'h0, 1'b1, 0, "R7 last word read");
        do_access(32'h0030_0000, 3'd2, 1'b0, 32'h0, 1'b1, 1, "R7 fully out read");
        do_access(32'h0030_0000, 3'd4, 1'b1, 32'h1111_1111, 1'b1, 0, "R7 fully out write");
        // R8 several accesses back to back with varying acknowledge delay
        for (int i = 0; i < 6; i++)
            do_access(32'h0000_4000 + i * 5, 3'(1 + (i % 4)), 1'b0, 32'h0, 1'b1, i[0], "R8 delay mix");

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule